// File: doc/BRIEF.md
# Channel-Programmed Divide-by-N Counter

This block sits in the feedback path of a frequency synthesiser. Its clock input is the oscillator signal after offset mixing. A channel selector supplies a 6-bit program word, and a mode bit selects transmit or receive. From these inputs the block forms a divide ratio N and divides its clock by N. The result is a one-clock comparison pulse for the phase detector, which runs at 5 kHz when the loop is locked.

Each count of N moves the locked oscillator by 5 kHz. Channels sit on a 10 kHz raster with a few irregular slots, so the transmit ratios climb in steps of two counts from 273 for channel 1. Receive mode uses the same table shifted down by 91 counts (455 kHz). This lets one reference serve both directions.

A program word that names no channel is flagged as invalid. While the word is invalid, the divider keeps running on the last good ratio. A new ratio is loaded only when the counter wraps, so the output never produces a shortened interval.

Top module: `chan_div_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `div_pulse` is 0, `code_valid` is 0 and `n_value` is 273 (channel 1, transmit).
- R2: The program word is the channel number in plain binary. Words 1 to 40 are valid, and words 0 and 41 to 63 are invalid. `code_valid` shows the validity of the word sampled on the previous clock edge.
- R3: With `rx_mode` = 0, `n_value` is 273 + 2·k for a valid word, one clock after that word is presented. The slot k is the channel's offset from channel 1 in 10 kHz steps. For channels 1–3, k = ch−1. A skipped slot follows each of channels 3, 7, 11, 15 and 19. Channel 23 has k = 29, channels 24 and 25 have k = 27 and 28, and channels 26–40 have k = ch+4.
- R4: With `rx_mode` = 1, `n_value` equals the transmit value for the same channel minus 91. This gives 182–270 across the table.
- R5: `div_pulse` is high for exactly one clock. Successive rising edges of the pulse are exactly N input clocks apart.
- R6: While the word is invalid, `n_value` holds the last valid N and the pulse spacing stays at that N.
- R7: If the channel changes during a divide period, that period completes with the old N. The next period uses the new N, so no interval is shorter than both ratios.
- R8: A change of `rx_mode` alone follows the same rule as R7, with the ratio moving by 91 counts at the next wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Offset-mixed oscillator signal that is divided |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_code | input | 6 | Channel program word, channel number in binary |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| div_pulse | output | 1 | One-clock pulse per divide period |
| n_value | output | 10 | Divide ratio currently selected |
| code_valid | output | 1 | High when the previous word named a channel 1–40 |

## Verification
The embedded properties assume the table never yields a ratio below two. They also assume the program word and mode bit are synchronous to the divided clock. If either assumption fails, the one-clock pulse width and the count-down-by-one step would not hold. The bench keeps within these assumptions by changing the inputs only on the falling edge. It only uses ratios from the defined table (182 to 361). Mid-period retunes are placed at least ten clocks away from a wrap, so the expected interval is fixed by the rule in R7.

// File: rtl/chan_div_pkg.sv
package chan_div_pkg;

   // Raster slot (10 kHz units from channel 1) for a channel number 1..40.
   function automatic int unsigned chan_slot(input int unsigned ch);
      int unsigned k;
      if (ch == 23) return 29;
      if (ch == 24 || ch == 25) return ch + 3;
      k = ch - 1;
      if (ch > 3)  k = k + 1;
      if (ch > 7)  k = k + 1;
      if (ch > 11) k = k + 1;
      if (ch > 15) k = k + 1;
      if (ch > 19) k = k + 1;
      return k;
   endfunction

   // Largest slot among channels 1..num
   function automatic int unsigned max_slot(input int unsigned num);
      int unsigned m;
      m = 0;
      for (int unsigned c = 1; c <= num; c++)
         if (chan_slot(c) > m) m = chan_slot(c);
      return m;
   endfunction

endpackage

// File: rtl/chan_n_lookup.sv
module chan_n_lookup
   import chan_div_pkg::*;
#(
   parameter int CODE_W     = 6,
   parameter int N_W        = 10,
   parameter int NUM_CHAN   = 40,
   parameter int N_BASE     = 273,
   parameter int SLOT_CNT   = 2,
   parameter int MODE_SHIFT = 91
) (
   input  logic [CODE_W-1:0] code,
   input  logic              rx_mode,
   output logic              hit,
   output logic [N_W-1:0]    n_raw
);
   localparam int IDX_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

   logic [N_W-1:0]   tx_tbl [NUM_CHAN];
   logic [IDX_W-1:0] idx;
   logic [N_W-1:0]   n_tx;

   generate
      for (genvar c = 0; c < NUM_CHAN; c++) begin : g_tbl
         assign tx_tbl[c] = N_W'(N_BASE + SLOT_CNT * int'(chan_slot(c + 1)));
      end
   endgenerate

   always_comb begin
      hit  = (code != '0) && (int'(code) <= NUM_CHAN);
      idx  = hit ? IDX_W'(int'(code) - 1) : '0;
      n_tx = tx_tbl[idx];
      n_raw = rx_mode ? (n_tx - N_W'(MODE_SHIFT)) : n_tx;
   end

endmodule

// File: rtl/chan_n_hold.sv
module chan_n_hold #(
   parameter int N_W   = 10,
   parameter int N_RST = 273,
   parameter int N_MIN = 182,
   parameter int N_MAX = 361
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hit,
   input  logic [N_W-1:0] n_raw,
   output logic [N_W-1:0] n_tgt,
   output logic           valid_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_tgt   <= N_W'(N_RST);
         valid_q <= 1'b0;
      end else begin
         valid_q <= hit;
         if (hit) n_tgt <= n_raw;
      end
   end

   // R6
   hold_on_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(n_tgt));

   // R3
   n_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(n_tgt) >= N_MIN) && (int'(n_tgt) <= N_MAX));

endmodule

// File: rtl/chan_div_counter.sv
module chan_div_counter #(
   parameter int N_W     = 10,
   parameter int N_RST   = 273,
   parameter int N_MAX   = 361,
   parameter bit REG_OUT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N_W-1:0] n_load,
   output logic           pulse
);
   logic [N_W-1:0] cnt;
   logic           wrap;

   assign wrap = (cnt == '0);

   // Reload only at terminal count: a new ratio never cuts a period short.
   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= N_W'(N_RST - 1);
      else if (wrap)   cnt <= n_load - 1'b1;
      else             cnt <= cnt - 1'b1;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= wrap;
         end
         assign pulse = pulse_q;
      end else begin : g_comb
         assign pulse = wrap & rst_n;
      end
   endgenerate

   // R7
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < N_MAX);

   // R5
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

endmodule

// File: rtl/chan_div_top.sv
module chan_div_top
   import chan_div_pkg::*;
#(
   parameter int CODE_W     = 6,
   parameter int N_W        = 10,
   parameter int NUM_CHAN   = 40,
   parameter int N_BASE     = 273,
   parameter int SLOT_CNT   = 2,
   parameter int MODE_SHIFT = 91,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] chan_code,
   input  logic              rx_mode,
   output logic              div_pulse,
   output logic [N_W-1:0]    n_value,
   output logic              code_valid
);
   localparam int N_MAX = N_BASE + SLOT_CNT * int'(max_slot(NUM_CHAN));
   localparam int N_MIN = N_BASE - MODE_SHIFT;

   generate
      if (N_MAX >= (1 << N_W)) begin : g_bad_width
         $error("N_W too small for largest ratio");
      end
      if (N_MIN < 2) begin : g_bad_min
         $error("smallest ratio must be at least 2");
      end
      if (NUM_CHAN < 1 || NUM_CHAN >= (1 << CODE_W)) begin : g_bad_chan
         $error("NUM_CHAN does not fit the program word");
      end
   endgenerate

   logic           hit;
   logic [N_W-1:0] n_raw;
   logic [N_W-1:0] n_tgt;
   logic           valid_q;

   chan_n_lookup #(
      .CODE_W(CODE_W), .N_W(N_W), .NUM_CHAN(NUM_CHAN), .N_BASE(N_BASE),
      .SLOT_CNT(SLOT_CNT), .MODE_SHIFT(MODE_SHIFT)
   ) u_lookup (
      .code(chan_code), .rx_mode(rx_mode), .hit(hit), .n_raw(n_raw)
   );

   chan_n_hold #(
      .N_W(N_W), .N_RST(N_BASE), .N_MIN(N_MIN), .N_MAX(N_MAX)
   ) u_hold (
      .clk(clk), .rst_n(rst_n), .hit(hit), .n_raw(n_raw),
      .n_tgt(n_tgt), .valid_q(valid_q)
   );

   chan_div_counter #(
      .N_W(N_W), .N_RST(N_BASE), .N_MAX(N_MAX), .REG_OUT(REG_OUT)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .n_load(n_tgt), .pulse(div_pulse)
   );

   assign n_value    = n_tgt;
   assign code_valid = valid_q;

   // R2
   valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((chan_code == '0) || (int'(chan_code) > NUM_CHAN)) |=> !code_valid);

   // R4
   rx_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && rx_mode) |=> (int'(n_value) <= N_MAX - MODE_SHIFT));

endmodule

// File: tb/sim_chan_div_top.sv
module sim_chan_div_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] chan_code = 6'd1;
   logic       rx_mode = 1'b0;
   logic       div_pulse;
   logic [9:0] n_value;
   logic       code_valid;

   int checks = 0;
   int errors = 0;
   localparam int GAP_LIMIT = 2000;

   always #10 clk = ~clk;

   chan_div_top u0 (
      .clk(clk), .rst_n(rst_n), .chan_code(chan_code), .rx_mode(rx_mode),
      .div_pulse(div_pulse), .n_value(n_value), .code_valid(code_valid)
   );

   // Expected transmit ratio from the channel's carrier frequency (kHz).
   function automatic int exp_n(input int ch, input bit rx);
      int f;
      if (ch <= 3)       f = 26965 + 10 * (ch - 1);
      else if (ch <= 7)  f = 27005 + 10 * (ch - 4);
      else if (ch <= 11) f = 27055 + 10 * (ch - 8);
      else if (ch <= 15) f = 27105 + 10 * (ch - 12);
      else if (ch <= 19) f = 27155 + 10 * (ch - 16);
      else if (ch <= 22) f = 27205 + 10 * (ch - 20);
      else if (ch == 23) f = 27255;
      else if (ch <= 25) f = 27235 + 10 * (ch - 24);
      else               f = 27265 + 10 * (ch - 26);
      return 273 + (f - 26965) / 5 - (rx ? 91 : 0);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Count clocks (at falling edges) until the next pulse; start offset given.
   task automatic wait_pulse(input int pre, output int gap);
      gap = pre;
      do begin
         @(negedge clk);
         gap++;
      end while (!div_pulse && gap < GAP_LIMIT);
      if (gap >= GAP_LIMIT) chk("R5 timeout", gap, -1);
   endtask

   task automatic apply(input int ch, input bit rx);
      @(negedge clk);
      chan_code = 6'(ch);
      rx_mode   = rx;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R1 pulse in reset", int'(div_pulse), 0);
      chk("R1 valid in reset", int'(code_valid), 0);
      chk("R1 n in reset", int'(n_value), 273);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pulse after reset", int'(div_pulse), 0);
      chk("R1 n after reset", int'(n_value), 273);
   endtask

   task automatic t_table(input bit rx);
      for (int ch = 1; ch <= 40; ch++) begin
         apply(ch, rx);
         @(negedge clk);
         chk(rx ? "R4 rx table" : "R3 tx table", int'(n_value), exp_n(ch, rx));
         chk("R2 valid code", int'(code_valid), 1);
      end
   endtask

   task automatic t_invalid_codes;
      int bad [4] = '{0, 41, 50, 63};
      apply(12, 1'b0);
      @(negedge clk);
      foreach (bad[i]) begin
         chan_code = 6'(bad[i]);
         @(negedge clk);
         @(negedge clk);
         chk("R2 invalid flag", int'(code_valid), 0);
         chk("R6 hold n", int'(n_value), exp_n(12, 1'b0));
      end
   endtask

   task automatic t_period(input int ch, input bit rx);
      int g;
      apply(ch, rx);
      wait_pulse(0, g);
      wait_pulse(0, g);
      for (int p = 0; p < 2; p++) begin
         wait_pulse(0, g);
         chk("R5 period", g, exp_n(ch, rx));
      end
   endtask

   task automatic t_retune(input int ch_a, input bit rx_a,
                           input int ch_b, input bit rx_b, input string req);
      int g;
      t_period(ch_a, rx_a);
      repeat (10) @(negedge clk);
      chan_code = 6'(ch_b);
      rx_mode   = rx_b;
      wait_pulse(10, g);
      chk({req, " old period kept"}, g, exp_n(ch_a, rx_a));
      wait_pulse(0, g);
      chk({req, " new period"}, g, exp_n(ch_b, rx_b));
   endtask

   task automatic t_invalid_mid;
      int g;
      t_period(30, 1'b0);
      repeat (5) @(negedge clk);
      chan_code = 6'd55;
      wait_pulse(5, g);
      chk("R6 period during invalid", g, exp_n(30, 1'b0));
      wait_pulse(0, g);
      chk("R6 period held", g, exp_n(30, 1'b0));
      chk("R6 n held", int'(n_value), exp_n(30, 1'b0));
      chk("R2 flag low", int'(code_valid), 0);
   endtask

   initial begin
      t_reset();
      t_table(1'b0);
      t_table(1'b1);
      t_invalid_codes();
      t_period(1, 1'b1);
      t_period(40, 1'b0);
      t_period(23, 1'b0);
      t_retune(5, 1'b0, 36, 1'b0, "R7 up");
      t_retune(36, 1'b1, 2, 1'b1, "R7 down");
      t_retune(17, 1'b0, 17, 1'b1, "R8 to rx");
      t_retune(17, 1'b1, 17, 1'b0, "R8 to tx");
      t_invalid_mid();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule